// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Fault Classes

This block turns a 32-bit virtual address into a physical one. It uses a translation buffer with 4 ways of 16 entries and a page size of 8 KB. There are two copies of the buffer. An execute access reads the instruction copy. Every other access reads the data copy. Bits [16:13] of the address pick one entry in each way, and all ways are compared in parallel. When a way hits, a fixed chain of protection checks either grants read, write and execute permission, or raises a fault with its own vector number.

The lookup is combinational from the stored entries, so results are valid in the same cycle the address is applied. When `lookup` is high and `probe` is low, a fault commits on the next clock edge. At that edge a 16-bit LFSR advances, a select register records the entry index and way, and a cause register records the page, access type and process ID. A probe lookup returns the same results but changes no state. Entries are loaded one at a time through a write port whose fields follow the entry layout. No data flows through the block, so every pin is a plain control or status pin and there is no back-pressure.

Top module: `xlat_tlb`

## Requirements
- R1: **Hit rule.** A way hits when its stored 19-bit page number equals `vaddr[31:13]`, and either its global flag is set or its stored PID equals `cur_pid`. When several ways hit, the lowest-numbered way is used.
- R2: **Physical address.** `paddr` is `{pfn, vaddr[12:0]}`, where `pfn` comes from the matching way. The upper 19 bits are zero when no way matches.
- R3: **Permissions.**
  - When the lookup succeeds (`hit`=1), `perm_r` is 1 and `perm_w` follows the entry's write flag.
  - `perm_x` is 1 only for an execute access (`acc_type`=2) when `chk_en[1]` or the entry's execute flag is set.
  - On a fault all three permissions are 0.
- R4: **Protection checks.** These checks run on a matching way in this priority order:
  1. `chk_en[2]` and `user_mode` and the entry's kernel flag give vector base+2.
  2. A write with `chk_en[3]` and the entry's write flag clear gives base+3.
  3. An execute with `chk_en[1]` and the entry's execute flag clear gives base+3.
  4. `chk_en[0]` and the entry's valid flag clear gives base+1.
  
  If none of these applies, `hit`=1 and `fault_vec`=0.
- R5: **Miss vector.** When no way matches, `fault_vec` is base+0. The base is 4 for an execute access and 8 for any other access.
- R6: **Refill way.** The LFSR resets to 0xCCCC. Each step shifts it right by one and loads bit 15 with the parity of `lfsr & 0x8805`. It steps once per committed fault. On a miss the reported way is `lfsr[1:0]` taken before that step. On a protection fault the matching way is reported.
- R7: **Select register.** On a committed fault, `sel_reg` becomes the entry index in [3:0], the way in [5:4], and zero in every other bit. It resets to 0.
- R8: **Cause register.** On a committed fault, `cause_reg[31:13]` takes `vaddr[31:13]`, [9:8] takes the access type and [7:0] takes `cur_pid`. Bits [12:10] keep their value. The register resets to 0.
- R9: **Probe.** A fault seen with `probe`=1, or with `lookup`=0, leaves `sel_reg`, `cause_reg` and the LFSR unchanged.
- R10: **Entry writes.** When `wr_en` is high, the entry at (`wr_side`: 0 = instruction, 1 = data; `wr_way`; `wr_idx`) is loaded with the values below. A lookup sees the new entry from the next cycle on.
  - `wr_vpn`, `wr_pid` and `wr_pfn`.
  - `wr_flags` = {global, valid, kernel, write, execute}, bits [4:0].
- R11: **Access type.** `acc_type` is 0 for read, 1 for write and 2 for execute. The value 3 behaves as a read, including the code 0 it writes into the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | 0 = instruction buffer, 1 = data buffer |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 19 | Virtual page number for the entry |
| wr_pid | input | 8 | Process ID for the entry |
| wr_pfn | input | 19 | Physical frame number for the entry |
| wr_flags | input | 5 | {global, valid, kernel, write, execute} |
| vaddr | input | 32 | Virtual address to translate |
| acc_type | input | 2 | 0 read, 1 write, 2 execute |
| user_mode | input | 1 | Access comes from user mode |
| cur_pid | input | 8 | Current process ID |
| chk_en | input | 4 | Check enables {write, kernel, execute, valid} |
| lookup | input | 1 | Lookup strobe; a fault commits at the next edge |
| probe | input | 1 | Side-effect-free lookup |
| paddr | output | 32 | Physical address |
| hit | output | 1 | Translation succeeded |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |
| fault_vec | output | 4 | Fault vector; 0 on a hit |
| sel_reg | output | 32 | Entry select register |
| cause_reg | output | 32 | Fault cause register |

## Verification
The stored pages and lookup addresses are drawn from a small pool of page numbers, so hits, misses, global matches and PID mismatches all occur often. Random check enables, user mode and access types then reach each protection class. Several faults can compete on one entry, which tells the priority order apart from any other order. Long runs of committed misses expose the LFSR sequence through the way field of the select register. Probe cycles and idle cycles that fault show whether side effects leak. Lookups right after a write show that the new entry is used.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 19;
  localparam int PID_W  = 8;
  localparam int PAGE_SH = 13;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2} acc_t;

  typedef enum logic [2:0] {
    FK_NONE, FK_MISS, FK_INVAL, FK_KERN, FK_PROT
  } fault_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] pfn;
    logic             g;
    logic             v;
    logic             k;
    logic             w;
    logic             x;
  } tlb_ent_t;

  function automatic logic [1:0] vec_off(fault_t f);
    case (f)
      FK_INVAL: return 2'd1;
      FK_KERN:  return 2'd2;
      FK_PROT:  return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int NWAYS = 4,
  parameter int NSETS = 16,
  localparam int IDX_W = $clog2(NSETS),
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [WAY_W-1:0]            wway,
  input  logic [IDX_W-1:0]            widx,
  input  tlb_ent_t                    went,
  input  logic [IDX_W-1:0]            ridx,
  output tlb_ent_t [NWAYS-1:0]        rd
);
  tlb_ent_t mem [NWAYS][NSETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWAYS; w++)
        for (int s = 0; s < NSETS; s++)
          mem[w][s] <= '0;
    end else if (we) begin
      mem[wway][widx] <= went;
    end
  end

  always_comb begin
    for (int w = 0; w < NWAYS; w++)
      rd[w] = mem[w][ridx];
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int NWAYS = 4,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  tlb_ent_t [NWAYS-1:0] ways,
  input  logic [VPN_W-1:0]     vpn,
  input  logic [PID_W-1:0]     pid,
  input  logic [3:0]           chk_en,
  input  acc_t                 acc,
  input  logic                 user,
  input  logic                 is_instr,
  output fault_t               kind,
  output logic [WAY_W-1:0]     mway,
  output logic [VPN_W-1:0]     pfn,
  output logic                 pw,
  output logic                 px
);
  logic     found;
  tlb_ent_t ent;

  always_comb begin
    found = 1'b0;
    mway  = '0;
    ent   = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (!found && ways[w].vpn == vpn && (ways[w].g || ways[w].pid == pid)) begin
        found = 1'b1;
        mway  = WAY_W'(w);
        ent   = ways[w];
      end
    end
  end

  always_comb begin
    if (!found)                                     kind = FK_MISS;
    else if (chk_en[2] && ent.k && user)            kind = FK_KERN;
    else if (acc == ACC_WR && chk_en[3] && !ent.w)  kind = FK_PROT;
    else if (acc == ACC_EX && chk_en[1] && !ent.x)  kind = FK_PROT;
    else if (chk_en[0] && !ent.v)                   kind = FK_INVAL;
    else                                            kind = FK_NONE;
  end

  assign pfn = ent.pfn;
  assign pw  = ent.w;
  assign px  = is_instr && (chk_en[1] || ent.x);
endmodule

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter logic [15:0] SEED = 16'hCCCC,
  parameter logic [15:0] TAPS = 16'h8805
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [15:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SEED;
    else if (step) q <= {^(q & TAPS), q[15:1]};
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int NWAYS = 4,
  parameter int NSETS = 16,
  localparam int IDX_W = $clog2(NSETS),
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_side,
  input  logic [WAY_W-1:0]   wr_way,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [18:0]        wr_vpn,
  input  logic [7:0]         wr_pid,
  input  logic [18:0]        wr_pfn,
  input  logic [4:0]         wr_flags,
  input  logic [31:0]        vaddr,
  input  logic [1:0]         acc_type,
  input  logic               user_mode,
  input  logic [7:0]         cur_pid,
  input  logic [3:0]         chk_en,
  input  logic               lookup,
  input  logic               probe,
  output logic [31:0]        paddr,
  output logic               hit,
  output logic               perm_r,
  output logic               perm_w,
  output logic               perm_x,
  output logic [3:0]         fault_vec,
  output logic [31:0]        sel_reg,
  output logic [31:0]        cause_reg
);
  localparam int NSIDES = 2;

  acc_t                 acc_n;
  logic                 is_instr;
  logic [IDX_W-1:0]     idx;
  logic [VPN_W-1:0]     vpn;
  tlb_ent_t             went;
  tlb_ent_t [NWAYS-1:0] side_rd [NSIDES];
  tlb_ent_t [NWAYS-1:0] ways;

  assign acc_n    = (acc_type == 2'd3) ? ACC_RD : acc_t'(acc_type);
  assign is_instr = (acc_n == ACC_EX);
  assign vpn      = vaddr[31:PAGE_SH];
  assign idx      = vaddr[PAGE_SH +: IDX_W];
  assign went     = '{vpn: wr_vpn, pid: wr_pid, pfn: wr_pfn,
                      g: wr_flags[4], v: wr_flags[3], k: wr_flags[2],
                      w: wr_flags[1], x: wr_flags[0]};

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    tlb_array #(.NWAYS(NWAYS), .NSETS(NSETS)) u_arr (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en && (wr_side == 1'(s))),
      .wway (wr_way),
      .widx (wr_idx),
      .went (went),
      .ridx (idx),
      .rd   (side_rd[s])
    );
  end

  assign ways = is_instr ? side_rd[0] : side_rd[1];

  fault_t           kind;
  logic [WAY_W-1:0] mway;
  logic [VPN_W-1:0] pfn;
  logic             pw, px;

  tlb_match #(.NWAYS(NWAYS)) u_match (
    .ways    (ways),
    .vpn     (vpn),
    .pid     (cur_pid),
    .chk_en  (chk_en),
    .acc     (acc_n),
    .user    (user_mode),
    .is_instr(is_instr),
    .kind    (kind),
    .mway    (mway),
    .pfn     (pfn),
    .pw      (pw),
    .px      (px)
  );

  logic [15:0] lfsr;
  logic        commit;
  logic [3:0]  vbase;

  assign hit       = (kind == FK_NONE);
  assign paddr     = {pfn, vaddr[PAGE_SH-1:0]};
  assign perm_r    = hit;
  assign perm_w    = hit && pw;
  assign perm_x    = hit && px;
  assign vbase     = is_instr ? 4'd4 : 4'd8;
  assign fault_vec = hit ? 4'd0 : (vbase + {2'b00, vec_off(kind)});
  assign commit    = lookup && !probe && !hit;

  tlb_lfsr u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (commit),
    .q    (lfsr)
  );

  logic [WAY_W-1:0] rep_way;
  assign rep_way = (kind == FK_MISS) ? lfsr[WAY_W-1:0] : mway;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_reg   <= '0;
      cause_reg <= '0;
    end else if (commit) begin
      sel_reg               <= (32'(rep_way) << IDX_W) | 32'(idx);
      cause_reg[31:PAGE_SH] <= vpn;
      cause_reg[9:8]        <= acc_n;
      cause_reg[7:0]        <= cur_pid;
    end
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lookup,
  input logic        probe,
  input logic [1:0]  acc_type,
  input logic [7:0]  cur_pid,
  input logic        hit,
  input logic        perm_r,
  input logic        perm_w,
  input logic        perm_x,
  input logic [3:0]  fault_vec,
  input logic [31:0] sel_reg,
  input logic [31:0] cause_reg
);
  // R9
  no_side_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lookup && !probe && !hit) |=> ($stable(sel_reg) && $stable(cause_reg)));

  // R3
  hit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> perm_r);

  // R3
  fault_noperm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !(perm_r || perm_w || perm_x));

  // R3
  exec_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_x |-> acc_type == 2'd2);

  // R5
  ivec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_type == 2'd2) |-> fault_vec[3:2] == 2'b01);

  // R5
  dvec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_type != 2'd2) |-> fault_vec[3:2] == 2'b10);

  // R7
  sel_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && !probe && !hit) |=> sel_reg[31:6] == '0);

  // R8
  cause_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && !probe && !hit) |=> cause_reg[7:0] == $past(cur_pid));
endmodule

bind xlat_tlb xlat_tlb_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lookup   (lookup),
  .probe    (probe),
  .acc_type (acc_type),
  .cur_pid  (cur_pid),
  .hit      (hit),
  .perm_r   (perm_r),
  .perm_w   (perm_w),
  .perm_x   (perm_x),
  .fault_vec(fault_vec),
  .sel_reg  (sel_reg),
  .cause_reg(cause_reg)
);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, wr_side = 0;
  logic [1:0]  wr_way = 0;
  logic [3:0]  wr_idx = 0;
  logic [18:0] wr_vpn = 0, wr_pfn = 0;
  logic [7:0]  wr_pid = 0;
  logic [4:0]  wr_flags = 0;
  logic [31:0] vaddr = 0;
  logic [1:0]  acc_type = 0;
  logic        user_mode = 0;
  logic [7:0]  cur_pid = 0;
  logic [3:0]  chk_en = 0;
  logic        lookup = 0, probe = 0;
  logic [31:0] paddr, sel_reg, cause_reg;
  logic        hit, perm_r, perm_w, perm_x;
  logic [3:0]  fault_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xlat_tlb dut (.*);

  // behavioural reference state
  int m_vpn [2][4][16];
  int m_pid [2][4][16];
  int m_pfn [2][4][16];
  int m_fl  [2][4][16];
  int m_lfsr;
  logic [31:0] m_sel, m_cause;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++)
        for (int i = 0; i < 16; i++) begin
          m_vpn[s][w][i] = 0; m_pid[s][w][i] = 0;
          m_pfn[s][w][i] = 0; m_fl[s][w][i] = 0;
        end
    m_lfsr = 'hCCCC;
    m_sel = 0;
    m_cause = 0;
  endtask

  // drive current inputs already set; compare, then advance model
  task automatic eval_and_step();
    int acc, side, vp, ix, fw, fl, vec, rway;
    bit found, e_hit;
    logic [31:0] e_pa;
    string vtag;
    acc  = (acc_type == 3) ? 0 : acc_type;
    side = (acc == 2) ? 0 : 1;
    vp   = vaddr[31:13];
    ix   = vp % 16;
    found = 0; fw = 0; fl = 0;
    for (int w = 3; w >= 0; w--) begin
      if (m_vpn[side][w][ix] == vp &&
          ((m_fl[side][w][ix] & 16) != 0 || m_pid[side][w][ix] == cur_pid)) begin
        found = 1; fw = w; fl = m_fl[side][w][ix];
      end
    end
    // fault classification (R4/R5)
    vec = 0;
    if (!found) vec = 0;
    else if (chk_en[2] && user_mode && (fl & 4)) vec = 2;
    else if (acc == 1 && chk_en[3] && !(fl & 2)) vec = 3;
    else if (acc == 2 && chk_en[1] && !(fl & 1)) vec = 3;
    else if (chk_en[0] && !(fl & 8)) vec = 1;
    else vec = -1;
    e_hit = (vec < 0);
    e_pa = {(found ? 19'(m_pfn[side][fw][ix]) : 19'd0), vaddr[12:0]};
    #1;
    chk("R1 hit", 32'(hit), 32'(e_hit));
    chk("R2 paddr", paddr, e_pa);
    chk("R3 perm", {29'd0, perm_r, perm_w, perm_x},
        {29'd0, e_hit, e_hit && (fl & 2) != 0,
         e_hit && acc == 2 && (chk_en[1] || (fl & 1) != 0)});
    vtag = found ? "R4 vector" : "R5 vector";
    chk(vtag, 32'(fault_vec),
        e_hit ? 32'd0 : 32'((side == 0 ? 4 : 8) + vec));
    chk(probe ? "R9 sel" : "R7 sel", sel_reg, m_sel);
    chk("R6 refill way", 32'(sel_reg[5:4]), 32'(m_sel[5:4]));
    chk(probe ? "R9 cause" : "R8 cause", cause_reg, m_cause);
    // model update for the coming edge
    if (lookup && !probe && !e_hit) begin
      rway = found ? fw : (m_lfsr & 3);
      m_sel = 32'(ix) | (32'(rway) << 4);
      m_cause[31:13] = vp[18:0];
      m_cause[9:8] = acc[1:0];
      m_cause[7:0] = cur_pid;
      m_lfsr = ((m_lfsr >> 1) | (($countones(m_lfsr & 'h8805) & 1) << 15)) & 'hFFFF;
    end
    if (wr_en) begin
      m_vpn[wr_side][wr_way][wr_idx] = wr_vpn;
      m_pid[wr_side][wr_way][wr_idx] = wr_pid;
      m_pfn[wr_side][wr_way][wr_idx] = wr_pfn;
      m_fl [wr_side][wr_way][wr_idx] = wr_flags;
    end
  endtask

  task automatic rand_inputs(bit allow_lookup);
    wr_en    = ($urandom % 3) == 0;
    wr_side  = 1'($urandom);
    wr_way   = 2'($urandom);
    wr_idx   = 4'($urandom);
    wr_vpn   = 19'((($urandom % 4) << 4) | wr_idx);
    wr_pid   = 8'($urandom % 4);
    wr_pfn   = 19'($urandom);
    wr_flags = 5'($urandom);
    vaddr    = {13'd0, 19'((($urandom % 4) << 4) | ($urandom % 16))} << 13 | 32'($urandom % 8192);
    if (($urandom % 16) == 0) vaddr = $urandom;
    acc_type  = 2'($urandom);
    user_mode = 1'($urandom);
    cur_pid   = 8'($urandom % 4);
    chk_en    = 4'($urandom);
    lookup    = allow_lookup && (($urandom % 4) != 0);
    probe     = ($urandom % 5) == 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    reset_model();
    repeat (3) @(negedge clk);
    // reset state, R7/R8
    chk("R7 sel reset", sel_reg, 32'd0);
    chk("R8 cause reset", cause_reg, 32'd0);
    rst_n = 1;

    // directed: miss after reset picks lfsr[1:0] = 0, then next value (R6)
    @(negedge clk);
    vaddr = 32'h8000_2000; acc_type = 2'd0; lookup = 1; chk_en = 4'hF;
    eval_and_step();
    @(negedge clk);
    eval_and_step();
    @(negedge clk);
    lookup = 0;
    eval_and_step();

    // directed R10: write a data entry, look it up next cycle
    @(negedge clk);
    wr_en = 1; wr_side = 1; wr_way = 2; wr_idx = 4'h5;
    wr_vpn = 19'h00015; wr_pid = 8'h07; wr_pfn = 19'h1ABCD; wr_flags = 5'b01010;
    vaddr = 32'h0002_A123; acc_type = 2'd1; cur_pid = 8'h07; lookup = 1;
    eval_and_step();
    @(negedge clk);
    wr_en = 0;
    eval_and_step();
    chk("R10 written entry hit", 32'(hit), 32'd1);

    // fill phase then mixed random traffic (R1..R11)
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      rand_inputs(0);
      wr_en = 1;
      eval_and_step();
    end
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      rand_inputs(1);
      eval_and_step();
    end
    // R11: access code 3 acts as a read on a committed fault
    @(negedge clk);
    wr_en = 0; probe = 0; lookup = 1; acc_type = 2'd3;
    vaddr = 32'hFFFF_E000; cur_pid = 8'h55;
    eval_and_step();
    @(negedge clk);
    lookup = 0;
    eval_and_step();
    chk("R11 cause code", 32'(cause_reg[9:8]), 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule